// File: doc/BRIEF.md
# Vendor Capability Register File

This block holds a vendor-specific extended capability as a small file of 32-bit words, read and written through one configuration port that addresses a 128-byte window by word index. Most words are fixed header and identification values set by parameters. A handful of fields are live: an accelerator-unit count that software may only lower, a mode byte holding a one-hot protocol area size and an accelerator-mode enable, and a pair of image reload controls.

Device status bits and a loaded-image flag come in from the rest of the device and are shown read-only. A pulse on the link reset input takes the stored reload controls. If a reload was requested, it sends out a one-cycle reload request carrying the chosen image and clears the stored request bit. Reads are combinational from the addressed word. A write takes effect at the clock edge where the write strobe is high.

Top module: `vcap_regfile`

## Requirements
- R1: Word 0 reads {NEXT_PTR[11:0], 4'h1, 16'h000B} and word 1 reads {12'h080, 4'h0, 16'h1280`}. Writes to both words are ignored.
- R2: After reset, word 2 holds the unit count at its power-on value UNITS_POR in bits 7:0, the area size SIZE_POR in bits 23:21 and the enable bit 16 equal to ACCEL_ONLY. In word 4, bits 29:28 are 0, and reload_req and reload_sel are 0.
- R3: A write to word 2 loads bits 7:0 into the unit count only when the value is below UNITS_POR. Otherwise the count keeps its value.
- R4: A write to word 2 loads bits 23:21 into the area size only when exactly one bit is set (100 = 1024 TB, 010 = 512 TB, 001 = 256 TB). Otherwise the size keeps its value.
- R5: When ACCEL_ONLY is 0, word 2 bit 16 is written from the write data: 1 selects accelerator mode and 0 selects plain PCIe mode.
- R6: Word 2 bits 15:8 show dev_status and word 4 bit 31 shows user_img_loaded (1 = user image, 0 = factory image). Writes do not change them.
- R7: A write to word 4 stores bit 29 (reload request) and bit 28 (image select: 0 = factory, 1 = user), and both read back in place.
- R8: A cycle with perst_pulse high clears stored bit 29. If bit 29 was set before that edge, reload_req is high for exactly the next cycle, and reload_sel then holds the stored bit 28. Otherwise reload_req stays low.
- R9: Reserved words (5 to 7 and 12 to 31) and reserved bits (word 2 bits 31:24 and 20:17, word 4 bits 30 and 27:16) read as zero, and writes to them change nothing.
- R10: Words 3, 8, 9, 10 and 11 read the parameters for the engine version and revision, descriptor offset, descriptor size, problem area offset and problem area size. The descriptor offset and size count 64 KB blocks, so the descriptor of unit n is at (offset + size × n) × 64K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W (5) | Word index into the 128-byte window |
| cfg_we | input | 1 | Write strobe for the addressed word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |
| dev_status | input | 8 | Read-only device status shown in word 2 bits 15:8 |
| user_img_loaded | input | 1 | 1 when the user image is loaded |
| perst_pulse | input | 1 | Link reset pulse that triggers a pending reload |
| reload_req | output | 1 | One-cycle image reload request |
| reload_sel | output | 1 | Image chosen for the reload: 0 factory, 1 user |

## Verification
The assertions take for granted that reset starts with SIZE_POR one-hot and UNITS_POR nonzero, and that perst_pulse and cfg_we are synchronous to clk and settled before each edge. The stimulus changes every input on the falling edge, so each write and each perst pulse covers exactly one rising edge.

The stimulus includes back-to-back perst pulses, where the second must find the request already cleared. It also includes writes that mix accepted and rejected fields in one word. This shows that each field is filtered on its own.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  localparam int WORD_W = 32;

  // header constants of the capability
  localparam logic [15:0] CAP_ID   = 16'h000B;
  localparam logic [3:0]  CAP_VER  = 4'h1;
  localparam logic [15:0] VEND_ID  = 16'h1280;
  localparam logic [3:0]  VEND_REV = 4'h0;
  localparam logic [11:0] CAP_LEN  = 12'h080;

  // word indices with content
  localparam int WI_HDR0 = 0;
  localparam int WI_HDR1 = 1;
  localparam int WI_CTRL = 2;
  localparam int WI_REV  = 3;
  localparam int WI_IMG  = 4;
  localparam int WI_DOFF = 8;
  localparam int WI_DSZ  = 9;
  localparam int WI_POFF = 10;
  localparam int WI_PSZ  = 11;

  typedef struct packed {
    logic [7:0] cnt;
    logic [2:0] size;
    logic       en;
  } ctrl_t;

  function automatic logic size_legal(input logic [2:0] v);
    return (v == 3'b001) || (v == 3'b010) || (v == 3'b100);
  endfunction

endpackage

// File: rtl/vcap_ctrl_regs.sv
module vcap_ctrl_regs
  import vcap_pkg::*;
#(
  parameter logic [7:0] UNITS_POR  = 8'd4,
  parameter logic [2:0] SIZE_POR   = 3'b001,
  parameter bit         ACCEL_ONLY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output ctrl_t       ctrl_q
);

  ctrl_t ctrl_n;
  logic  en_n;

  generate
    if (ACCEL_ONLY) begin : g_en_fixed
      assign en_n = 1'b1;
    end else begin : g_en_rw
      assign en_n = wdata[16];
    end
  endgenerate

  always_comb begin
    ctrl_n = ctrl_q;
    if (wdata[7:0] < UNITS_POR) ctrl_n.cnt = wdata[7:0];
    if (size_legal(wdata[23:21])) ctrl_n.size = wdata[23:21];
    ctrl_n.en = en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.cnt  <= UNITS_POR;
      ctrl_q.size <= SIZE_POR;
      ctrl_q.en   <= ACCEL_ONLY;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_n;
    end
  end

endmodule

// File: rtl/vcap_image_ctl.sv
module vcap_image_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_img,
  input  logic [31:0] wdata,
  input  logic        perst_pulse,
  output logic        req_q,
  output logic        sel_q,
  output logic        reload_req,
  output logic        reload_sel
);

  logic req_n, sel_n, fire_n;

  always_comb begin
    req_n = req_q;
    sel_n = sel_q;
    if (wr_img) begin
      req_n = wdata[29];
      sel_n = wdata[28];
    end
    if (perst_pulse) req_n = 1'b0;  // reset pulse wins over a write
    fire_n = perst_pulse && req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_img || perst_pulse) begin
      req_q <= req_n;
      sel_q <= sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_req <= 1'b0;
    end else begin
      reload_req <= fire_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_sel <= 1'b0;
    end else if (fire_n) begin
      reload_sel <= sel_q;
    end
  end

endmodule

// File: rtl/vcap_regfile.sv
module vcap_regfile
  import vcap_pkg::*;
#(
  parameter int          WINDOW_BYTES = 128,
  parameter logic [11:0] NEXT_PTR     = 12'h000,
  parameter logic [7:0]  UNITS_POR    = 8'd4,
  parameter logic [2:0]  SIZE_POR     = 3'b001,
  parameter bit          ACCEL_ONLY   = 1'b0,
  parameter logic [7:0]  VER_MAJOR    = 8'd1,
  parameter logic [7:0]  VER_MINOR    = 8'd0,
  parameter logic [15:0] ENGINE_REV   = 16'h0102,
  parameter logic [15:0] BASE_REV     = 16'h0011,
  parameter logic [31:0] DESC_OFF     = 32'h0000_0001,
  parameter logic [31:0] DESC_SIZE    = 32'h0000_0001,
  parameter logic [31:0] PROB_OFF     = 32'h0000_0002,
  parameter logic [31:0] PROB_SIZE    = 32'h0000_0001,
  localparam int         WORDS        = WINDOW_BYTES / 4,
  localparam int         ADDR_W       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [7:0]        dev_status,
  input  logic              user_img_loaded,
  input  logic              perst_pulse,
  output logic              reload_req,
  output logic              reload_sel
);

  ctrl_t ctrl_q;
  logic  wr_ctrl, wr_img;
  logic  img_req, img_sel;
  logic [7:0] unit_cnt;
  logic [2:0] area_size;

  assign wr_ctrl   = cfg_we && (cfg_addr == ADDR_W'(WI_CTRL));
  assign wr_img    = cfg_we && (cfg_addr == ADDR_W'(WI_IMG));
  assign unit_cnt  = ctrl_q.cnt;
  assign area_size = ctrl_q.size;

  vcap_ctrl_regs #(
    .UNITS_POR (UNITS_POR),
    .SIZE_POR  (SIZE_POR),
    .ACCEL_ONLY(ACCEL_ONLY)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wdata  (cfg_wdata),
    .ctrl_q (ctrl_q)
  );

  vcap_image_ctl u_img (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_img     (wr_img),
    .wdata      (cfg_wdata),
    .perst_pulse(perst_pulse),
    .req_q      (img_req),
    .sel_q      (img_sel),
    .reload_req (reload_req),
    .reload_sel (reload_sel)
  );

  always_comb begin
    cfg_rdata = '0;
    case (int'(cfg_addr))
      WI_HDR0: cfg_rdata = {NEXT_PTR, CAP_VER, CAP_ID};
      WI_HDR1: cfg_rdata = {CAP_LEN, VEND_REV, VEND_ID};
      WI_CTRL: cfg_rdata = {8'h00, ctrl_q.size, 4'h0, ctrl_q.en,
                            dev_status, ctrl_q.cnt};
      WI_REV:  cfg_rdata = {VER_MAJOR, VER_MINOR, ENGINE_REV};
      WI_IMG:  cfg_rdata = {user_img_loaded, 1'b0, img_req, img_sel,
                            12'h000, BASE_REV};
      WI_DOFF: cfg_rdata = DESC_OFF;
      WI_DSZ:  cfg_rdata = DESC_SIZE;
      WI_POFF: cfg_rdata = PROB_OFF;
      WI_PSZ:  cfg_rdata = PROB_SIZE;
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vcap_regfile_chk.sv
module vcap_regfile_chk #(
  parameter logic [7:0] UNITS_POR = 8'd4,
  parameter int         ADDR_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              perst_pulse,
  input logic              reload_req,
  input logic [7:0]        unit_cnt,
  input logic [2:0]        area_size,
  input logic              img_req
);

  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_addr == ADDR_W'(2));

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unit_cnt <= UNITS_POR);

  assert_cnt_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (cfg_wdata[7:0] >= UNITS_POR)) |=> $stable(unit_cnt));

  assert_size_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !$onehot(cfg_wdata[23:21])) |=> $stable(area_size));

  assert_size_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(area_size));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |-> $past(perst_pulse));

  assert_req_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perst_pulse |=> !img_req);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !reload_req);

endmodule

bind vcap_regfile vcap_regfile_chk #(
  .UNITS_POR(UNITS_POR),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .perst_pulse(perst_pulse),
  .reload_req (reload_req),
  .unit_cnt   (unit_cnt),
  .area_size  (area_size),
  .img_req    (img_req)
);

// File: tb/tb_vcap_regfile.sv
`timescale 1ns/1ps
module tb_vcap_regfile;

  localparam logic [7:0]  E_UNITS = 8'd4;
  localparam logic [15:0] E_BASE  = 16'h0011;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_addr;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [7:0]  dev_status;
  logic        user_img_loaded;
  logic        perst_pulse;
  logic        reload_req;
  logic        reload_sel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vcap_regfile dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_status(dev_status),
    .user_img_loaded(user_img_loaded), .perst_pulse(perst_pulse),
    .reload_req(reload_req), .reload_sel(reload_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pulse_perst();
    @(negedge clk);
    perst_pulse = 1'b1;
    @(negedge clk);
    perst_pulse = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    rd(5'd2, d); chk("R2 word2 reset", d, 32'h0020_A504);
    rd(5'd4, d); chk("R2 word4 reset", d, {16'h0000, E_BASE});
    chk("R2 reload_req reset", {31'd0, reload_req}, 32'd0);
    chk("R2 reload_sel reset", {31'd0, reload_sel}, 32'd0);
  endtask

  task automatic test_header();
    logic [31:0] d;
    rd(5'd0, d); chk("R1 word0", d, 32'h0001_000B);
    rd(5'd1, d); chk("R1 word1", d, 32'h0800_1280);
    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd1, 32'h0000_0000);
    rd(5'd0, d); chk("R1 word0 after write", d, 32'h0001_000B);
    rd(5'd1, d); chk("R1 word1 after write", d, 32'h0800_1280);
  endtask

  task automatic test_count();
    logic [31:0] d;
    wr(5'd2, 32'h0000_0002);
    rd(5'd2, d); chk("R3 lower to 2", {24'd0, d[7:0]}, 32'd2);
    wr(5'd2, 32'h0020_0005);
    rd(5'd2, d); chk("R3 reject above power-on", {24'd0, d[7:0]}, 32'd2);
    wr(5'd2, {24'h002000, E_UNITS});
    rd(5'd2, d); chk("R3 reject equal to power-on", {24'd0, d[7:0]}, 32'd2);
    wr(5'd2, 32'h0020_0000);
    rd(5'd2, d); chk("R3 accept zero", {24'd0, d[7:0]}, 32'd0);
    wr(5'd2, 32'h0020_0003);
    rd(5'd2, d); chk("R3 accept 3", {24'd0, d[7:0]}, 32'd3);
  endtask

  task automatic test_size();
    logic [31:0] d;
    rd(5'd2, d); chk("R4 size kept after zero code", {29'd0, d[23:21]}, 32'd1);
    wr(5'd2, 32'h0080_0003);
    rd(5'd2, d); chk("R4 accept 100", {29'd0, d[23:21]}, 32'd4);
    wr(5'd2, 32'h0060_0003);
    rd(5'd2, d); chk("R4 reject 011", {29'd0, d[23:21]}, 32'd4);
    wr(5'd2, 32'h00E0_0003);
    rd(5'd2, d); chk("R4 reject 111", {29'd0, d[23:21]}, 32'd4);
    wr(5'd2, 32'h0040_0003);
    rd(5'd2, d); chk("R4 accept 010", {29'd0, d[23:21]}, 32'd2);
  endtask

  task automatic test_enable();
    logic [31:0] d;
    wr(5'd2, 32'h0041_0003);
    rd(5'd2, d); chk("R5 enable set", {31'd0, d[16]}, 32'd1);
    wr(5'd2, 32'h0040_0003);
    rd(5'd2, d); chk("R5 enable cleared", {31'd0, d[16]}, 32'd0);
  endtask

  task automatic test_status_reserved_ctrl();
    logic [31:0] d;
    @(negedge clk);
    dev_status = 8'h3C;
    rd(5'd2, d); chk("R6 status follows input", d, 32'h0040_3C03);
    wr(5'd2, 32'hFF1E_FF03);
    rd(5'd2, d); chk("R6 R9 status and reserved bits unchanged", d, 32'h0040_3C03);
  endtask

  task automatic test_image();
    logic [31:0] d;
    @(negedge clk);
    user_img_loaded = 1'b1;
    wr(5'd4, 32'h3000_0000);
    rd(5'd4, d); chk("R7 request and select stored", d, {16'hB000, E_BASE});
    wr(5'd4, 32'h7FFF_FFFF);
    rd(5'd4, d); chk("R6 R9 loaded flag and reserved bits", d, {16'hB000, E_BASE});
    @(negedge clk);
    user_img_loaded = 1'b0;
    rd(5'd4, d); chk("R6 loaded flag follows input", d, {16'h3000, E_BASE});
  endtask

  task automatic test_perst();
    logic [31:0] d;
    pulse_perst();
    chk("R8 reload_req pulse", {31'd0, reload_req}, 32'd1);
    chk("R8 reload_sel user", {31'd0, reload_sel}, 32'd1);
    perst_pulse = 1'b1;
    @(negedge clk);
    perst_pulse = 1'b0;
    chk("R8 pulse one cycle", {31'd0, reload_req}, 32'd0);
    rd(5'd4, d); chk("R8 request bit cleared", d, {16'h1000, E_BASE});
    @(negedge clk);
    chk("R8 no pulse without request", {31'd0, reload_req}, 32'd0);
    wr(5'd4, 32'h2000_0000);
    pulse_perst();
    chk("R8 reload_req second", {31'd0, reload_req}, 32'd1);
    chk("R8 reload_sel factory", {31'd0, reload_sel}, 32'd0);
  endtask

  task automatic test_reserved_words();
    logic [31:0] d;
    wr(5'd5, 32'hFFFF_FFFF);
    wr(5'd16, 32'hFFFF_FFFF);
    wr(5'd31, 32'hFFFF_FFFF);
    for (int i = 5; i < 32; i++) begin
      if (i < 8 || i > 11) begin
        rd(5'(i), d); chk("R9 reserved word zero", d, 32'd0);
      end
    end
    rd(5'd2, d); chk("R9 word2 untouched", d, 32'h0040_3C03);
    rd(5'd4, d); chk("R9 word4 untouched", d, {16'h0000, E_BASE});
  endtask

  task automatic test_offsets();
    logic [31:0] d;
    rd(5'd3, d);  chk("R10 version word", d, 32'h0100_0102);
    rd(5'd8, d);  chk("R10 descriptor offset", d, 32'd1);
    rd(5'd9, d);  chk("R10 descriptor size", d, 32'd1);
    rd(5'd10, d); chk("R10 problem offset", d, 32'd2);
    rd(5'd11, d); chk("R10 problem size", d, 32'd1);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_addr = '0; cfg_we = 1'b0; cfg_wdata = '0;
    dev_status = 8'hA5; user_img_loaded = 1'b0; perst_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_header();
    test_count();
    test_size();
    test_enable();
    test_status_reserved_ctrl();
    test_image();
    test_perst();
    test_reserved_words();
    test_offsets();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule